// File: doc/BRIEF.md
# Mailbox Request Sequencer

This block is the requesting side of a small shared-register mailbox. The mailbox is eight 32-bit words, and word 7 holds the message header. Bit 31 of word 7 shows which side owns the mailbox. The sequencer takes one command, either *establish* or *destroy*, and carries it through to the end. An establish command carries four 64-bit queue base addresses (event, completion, receive, send), a vector index and a reset-function flag. A destroy command carries only the flag.

For an establish command the sequencer first checks the arguments. It then reads word 7 at a programmable interval until the owner bit is clear. Next it packs the message and writes it out, with word 7 written last. It then polls again until ownership comes back and checks the response header. It ends with a one-cycle `done` pulse and a two-bit result code: 0 ok, 1 invalid argument, 2 timeout, 3 protocol error. The code is held until the next command finishes. Each polling phase gives up after `MAX_POLLS` reads that find the owner bit set (20000 by default).

A read is issued by raising `mb_rd` with `mb_addr`. The mailbox must present the word on `mb_rdata` during the following cycle.

Top module: `mbox_req_seq`

## Requirements
- R1: After reset `busy`, `done`, `mb_rd` and `mb_wr` are 0 and `result` is 0 (ok).
- R2: An establish command whose address has any of bits [11:0] set, or whose `vec_idx` has any of bits [31:16] set, ends with result 1 (invalid argument). `done` is high in the second cycle after the start cycle, and the mailbox is neither read nor written.
- R3: Before any write, the block only reads word 7. It repeats the read until bit 31 of the returned word is 0. When `poll_gap` is G, there are G idle cycles between a read that finds the bit set and the next read.
- R4: If `MAX_POLLS` consecutive reads in one polling phase find bit 31 set, the command ends with result 2 (timeout). A timeout in the first phase leaves the mailbox unwritten.
- R5: An establish message is packed as follows, where frame number i is address i shifted right by 12 and the addresses are taken in the order event, completion, receive, send:
  - bytes 6i to 6i+5 hold bits [47:0] of frame number i, little-endian;
  - bits [4i+3:4i] of the 16-bit field at bytes 24–25 hold bits [51:48] of frame number i;
  - bytes 26–27 hold the vector index.

  Word k carries bytes 4k to 4k+3, with byte 4k in bits [7:0].
- R6: An establish command writes words 0 through 7 in consecutive cycles. A destroy command writes only word 7. In both cases the write to word 7 is the last write, and the next cycle reads word 7.
- R7: The header word written to word 7 carries the following fields; all other bits are 0:

  | Field | Bits | Value |
  |---|---|---|
  | Message type | [2:0] | 1 for establish, 2 for destroy |
  | Version | [5:3] | 0 |
  | Direction | [7] | 0 |
  | Status | [15:8] | 0 |
  | Reset flag | [24] | the reset-function flag |
- R8: In the response phase with the reset flag set, reading 0xFFFFFFFF ends the command with result 0. With the flag clear, that value counts as owner bit set.
- R9: In the response phase, the first word read with bit 31 clear is accepted (result 0) only if all of the following hold; otherwise the result is 3 (protocol error):
  - bits [2:0] equal the requested type;
  - bits [5:3] are at most 0;
  - bit 7 is 1;
  - bits [15:8] are 0.
- R10: While `busy` is high, `cmd_start` is ignored. `done` lasts one cycle, and `result` changes only in the cycle that `done` is high.
- R11: The read data is taken in the cycle after `mb_rd`. The start cycle with no wait is followed by `done` exactly 2 + P1 + W + P2 cycles later, where:
  - W is the number of words written;
  - a polling phase with b busy reads takes 2(b+1) + G·b cycles;
  - P1 and P2 are the durations of the first and second polling phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a command (taken only when idle) |
| cmd_destroy | input | 1 | 1 = destroy, 0 = establish |
| cmd_reset_fn | input | 1 | Reset-function flag placed in the header |
| q_evt_addr | input | 64 | Event queue base address |
| q_cmp_addr | input | 64 | Completion queue base address |
| q_rcv_addr | input | 64 | Receive queue base address |
| q_snd_addr | input | 64 | Send queue base address |
| vec_idx | input | 32 | Interrupt vector index, must fit in 16 bits |
| poll_gap | input | 16 | Idle cycles between busy polls |
| mb_rd | output | 1 | Mailbox read strobe |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_addr | output | 3 | Mailbox word index |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after `mb_rd` |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 invalid argument, 2 timeout, 3 protocol error |

## Verification
Faults in this block show up at the ports in a few distinct ways:
- A wrong phase flag or word counter shows up within a cycle as a write list that differs from the packed message, or as a write before the owner bit clears.
- A miscounted poll or gap counter does not change the write list. It moves the `done` pulse away from the cycle the latency formula predicts, or ends a run that should time out with a different code.
- An error in header or response decoding shows up as the wrong result code in the single `done` cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORDS    = 8;
  localparam int WORD_W   = 32;
  localparam int MSG_W    = WORDS * WORD_W;
  localparam int IDX_W    = $clog2(WORDS);
  localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(WORDS - 1);

  localparam logic [2:0] TYPE_EST = 3'd1;
  localparam logic [2:0] TYPE_DES = 3'd2;
  localparam logic [2:0] VER_REQ  = 3'd0;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_INVAL   = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_PROTO   = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ARGS, S_RD, S_RW, S_GAP, S_WR
  } seq_st_e;

  function automatic logic [WORD_W-1:0] req_header(input logic [2:0] mtype,
                                                   input logic rst_fn);
    logic [WORD_W-1:0] h;
    h       = '0;
    h[2:0]  = mtype;
    h[5:3]  = VER_REQ;
    h[7]    = 1'b0;
    h[24]   = rst_fn;
    return h;
  endfunction
endpackage

// File: rtl/mbox_msg_packer.sv
module mbox_msg_packer
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int FN_LO_W    = 48,
  parameter int NQ         = 4,
  parameter int VEC_W      = 16,
  parameter int VEC_IN_W   = 32
) (
  input  logic [NQ*ADDR_W-1:0] addrs,
  input  logic [VEC_IN_W-1:0]  vec,
  input  logic                 rst_fn,
  input  logic                 is_destroy,
  output logic [MSG_W-1:0]     msg,
  output logic                 args_ok
);
  localparam int FN_W    = ADDR_W - PAGE_SHIFT;
  localparam int FN_HI_W = FN_W - FN_LO_W;

  logic [NQ*FN_LO_W-1:0] lo_field;
  logic [NQ*FN_HI_W-1:0] hi_field;
  logic [NQ-1:0]         aligned;
  logic [WORD_W-1:0]     hdr;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [FN_W-1:0] fn;
    assign fn = addrs[q*ADDR_W+PAGE_SHIFT +: FN_W];
    assign lo_field[q*FN_LO_W +: FN_LO_W] = fn[FN_LO_W-1:0];
    assign hi_field[q*FN_HI_W +: FN_HI_W] = fn[FN_W-1:FN_LO_W];
    assign aligned[q] = (addrs[q*ADDR_W +: PAGE_SHIFT] == '0);
  end

  assign hdr     = req_header(is_destroy ? TYPE_DES : TYPE_EST, rst_fn);
  assign msg     = {hdr, vec[VEC_W-1:0], hi_field, lo_field};
  assign args_ok = is_destroy | ((&aligned) & (vec[VEC_IN_W-1:VEC_W] == '0));
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int MAX_POLLS = 20000,
  parameter int GAP_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             poll_busy,
  input  logic             gap_run,
  input  logic [GAP_W-1:0] gap_len,
  output logic             last_poll,
  output logic             gap_done
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [PW-1:0]    poll_q, poll_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    poll_d = poll_q;
    if (clr)            poll_d = '0;
    else if (poll_busy) poll_d = poll_q + PW'(1);
    gap_d = gap_run ? gap_q + GAP_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= '0;
      gap_q  <= '0;
    end else begin
      poll_q <= poll_d;
      gap_q  <= gap_d;
    end
  end

  assign last_poll = (poll_q == PW'(MAX_POLLS - 1));
  assign gap_done  = gap_run && (gap_q == gap_len - GAP_W'(1));
endmodule

// File: rtl/mbox_resp_check.sv
module mbox_resp_check
  import mbox_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        req_type,
  output logic              ok
);
  assign ok = (word[2:0] == req_type) && (word[5:3] <= VER_REQ) &&
              word[7] && (word[15:8] == 8'd0);
endmodule

// File: rtl/mbox_req_seq.sv
module mbox_req_seq
  import mbox_pkg::*;
#(
  parameter int MAX_POLLS = 20000,
  parameter int GAP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_destroy,
  input  logic              cmd_reset_fn,
  input  logic [63:0]       q_evt_addr,
  input  logic [63:0]       q_cmp_addr,
  input  logic [63:0]       q_rcv_addr,
  input  logic [63:0]       q_snd_addr,
  input  logic [31:0]       vec_idx,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              mb_rd,
  output logic              mb_wr,
  output logic [IDX_W-1:0]  mb_addr,
  output logic [WORD_W-1:0] mb_wdata,
  input  logic [WORD_W-1:0] mb_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result
);
  localparam int NQ = 4;
  localparam int AW = 64;

  seq_st_e              st_q, st_d;
  logic [IDX_W-1:0]     wcnt_q, wcnt_d;
  logic                 post_q, post_d;
  logic                 done_q, done_d;
  res_e                 res_q, res_d;
  logic                 ld;
  logic                 des_q, rstf_q;
  logic [NQ*AW-1:0]     addr_q;
  logic [31:0]          vec_q;
  logic [GAP_W-1:0]     gap_q;
  logic [MSG_W-1:0]     msg;
  logic                 args_ok, resp_ok;
  logic                 tmr_clr, poll_busy, last_poll, gap_done;

  mbox_msg_packer #(.ADDR_W(AW), .NQ(NQ)) packer_i (
    .addrs(addr_q), .vec(vec_q), .rst_fn(rstf_q), .is_destroy(des_q),
    .msg(msg), .args_ok(args_ok)
  );

  mbox_poll_timer #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .poll_busy(poll_busy),
    .gap_run(st_q == S_GAP), .gap_len(gap_q),
    .last_poll(last_poll), .gap_done(gap_done)
  );

  mbox_resp_check resp_i (
    .word(mb_rdata), .req_type(des_q ? TYPE_DES : TYPE_EST), .ok(resp_ok)
  );

  always_comb begin
    st_d      = st_q;
    wcnt_d    = wcnt_q;
    post_d    = post_q;
    done_d    = 1'b0;
    res_d     = res_q;
    ld        = 1'b0;
    tmr_clr   = 1'b0;
    poll_busy = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_start) begin
        ld   = 1'b1;
        st_d = S_ARGS;
      end
      S_ARGS: begin
        tmr_clr = 1'b1;
        post_d  = 1'b0;
        wcnt_d  = des_q ? HDR_IDX : '0;
        if (!args_ok) begin
          done_d = 1'b1;
          res_d  = RES_INVAL;
          st_d   = S_IDLE;
        end else begin
          st_d = S_RD;
        end
      end
      S_RD: st_d = S_RW;
      S_RW: begin
        if (post_q && rstf_q && (&mb_rdata)) begin
          done_d = 1'b1;
          res_d  = RES_OK;
          st_d   = S_IDLE;
        end else if (!mb_rdata[WORD_W-1]) begin
          if (!post_q) begin
            st_d = S_WR;
          end else begin
            done_d = 1'b1;
            res_d  = resp_ok ? RES_OK : RES_PROTO;
            st_d   = S_IDLE;
          end
        end else begin
          poll_busy = 1'b1;
          if (last_poll) begin
            done_d = 1'b1;
            res_d  = RES_TIMEOUT;
            st_d   = S_IDLE;
          end else begin
            st_d = (gap_q == '0) ? S_RD : S_GAP;
          end
        end
      end
      S_GAP: if (gap_done) st_d = S_RD;
      S_WR: begin
        if (wcnt_q == HDR_IDX) begin
          post_d  = 1'b1;
          tmr_clr = 1'b1;
          st_d    = S_RD;
        end else begin
          wcnt_d = wcnt_q + IDX_W'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      wcnt_q <= '0;
      post_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= RES_OK;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      post_q <= post_d;
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      des_q  <= 1'b0;
      rstf_q <= 1'b0;
      addr_q <= '0;
      vec_q  <= '0;
      gap_q  <= '0;
    end else if (ld) begin
      des_q  <= cmd_destroy;
      rstf_q <= cmd_reset_fn;
      addr_q <= {q_snd_addr, q_rcv_addr, q_cmp_addr, q_evt_addr};
      vec_q  <= vec_idx;
      gap_q  <= poll_gap;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign result   = res_q;
  assign mb_rd    = (st_q == S_RD);
  assign mb_wr    = (st_q == S_WR);
  assign mb_addr  = (st_q == S_RD) ? HDR_IDX : wcnt_q;
  assign mb_wdata = (st_q == S_WR) ? msg[wcnt_q*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/mbox_req_seq_chk.sv
module mbox_req_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  result,
  input logic        mb_rd,
  input logic        mb_wr,
  input logic [2:0]  mb_addr,
  input logic [31:0] mb_wdata
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_rd && mb_wr)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mb_rd && !mb_wr)); // R1

  AST_RD_HDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |-> (mb_addr == 3'd7)); // R3

  AST_WR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_addr != 3'd7) |=> (mb_wr && mb_addr == $past(mb_addr) + 3'd1)); // R6

  AST_WR_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_addr == 3'd7) |=> (mb_rd && mb_addr == 3'd7)); // R6

  AST_HDR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_addr == 3'd7) |-> (mb_wdata[7] == 1'b0 && mb_wdata[15:8] == 8'd0
                                    && mb_wdata[5:3] == 3'd0)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R10
endmodule

bind mbox_req_seq mbox_req_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_addr(mb_addr), .mb_wdata(mb_wdata)
);

// File: tb/mbox_req_seq_tb_top.sv
module mbox_req_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N = 20000;

  logic        clk, rst_n;
  logic        cmd_start, cmd_destroy, cmd_reset_fn;
  logic [63:0] a_evt, a_cmp, a_rcv, a_snd;
  logic [31:0] vec_idx;
  logic [15:0] poll_gap;
  logic        mb_rd, mb_wr, busy, done;
  logic [2:0]  mb_addr;
  logic [31:0] mb_wdata, mb_rdata;
  logic [1:0]  result;

  int checks = 0, fails = 0;
  int pre_left, post_left, nreads;
  logic [31:0] resp_word;
  bit wrote7;
  logic [34:0] wq[$];

  mbox_req_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_destroy(cmd_destroy),
    .cmd_reset_fn(cmd_reset_fn), .q_evt_addr(a_evt), .q_cmp_addr(a_cmp),
    .q_rcv_addr(a_rcv), .q_snd_addr(a_snd), .vec_idx(vec_idx), .poll_gap(poll_gap),
    .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_rdata(mb_rdata), .busy(busy), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural mailbox: reply lands in the cycle after the read strobe
  always @(negedge clk) begin
    if (mb_wr) begin
      wq.push_back({mb_addr, mb_wdata});
      if (mb_addr == 3'd7) wrote7 = 1'b1;
    end
    if (mb_rd) begin
      nreads++;
      if (!wrote7) begin
        if (pre_left > 0) begin mb_rdata = 32'h8000_0000; pre_left--; end
        else mb_rdata = 32'h0000_0000;
      end else begin
        if (post_left > 0) begin mb_rdata = 32'h8000_0001; post_left--; end
        else mb_rdata = resp_word;
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int phase_len(int b, int g);
    return 2 * (b + 1) + g * b;
  endfunction

  // expected message words built byte by byte
  function automatic logic [31:0] exp_word(int k, bit des, bit rf);
    logic [7:0]  by[32];
    logic [63:0] ad[4];
    logic [15:0] nib;
    ad[0] = a_evt; ad[1] = a_cmp; ad[2] = a_rcv; ad[3] = a_snd;
    nib = 16'h0;
    for (int q = 0; q < 4; q++) begin
      logic [51:0] fn;
      fn = ad[q][63:12];
      for (int b = 0; b < 6; b++) by[6*q+b] = fn[8*b +: 8];
      nib = nib | (16'(fn[51:48]) << (4 * q));
    end
    by[24] = nib[7:0];  by[25] = nib[15:8];
    by[26] = vec_idx[7:0]; by[27] = vec_idx[15:8];
    by[28] = des ? 8'h02 : 8'h01; by[29] = 8'h00; by[30] = 8'h00;
    by[31] = {7'd0, rf};
    return {by[4*k+3], by[4*k+2], by[4*k+1], by[4*k]};
  endfunction

  // runs one command; poke issues an extra start while busy
  task automatic run(string req, bit des, bit rf, int g, int b1, int b2,
                     logic [31:0] rw, logic [1:0] exp_res, int exp_lat,
                     int exp_writes, bit poke);
    int n;
    pre_left = b1; post_left = b2; resp_word = rw; wrote7 = 1'b0;
    nreads = 0; wq.delete();
    cmd_destroy = des; cmd_reset_fn = rf; poll_gap = 16'(g);
    cmd_start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin cmd_start = 1'b1; cmd_destroy = ~des; end
      else cmd_start = 1'b0;
    end while (!done && n < 150000);
    cmd_start = 1'b0;
    check({req, " result"}, 64'(result), 64'(exp_res));
    check({req, " done cycle"}, 64'(n), 64'(exp_lat));
    check({req, " write count"}, 64'(wq.size()), 64'(exp_writes));
    if (exp_writes == 8 && wq.size() == 8) begin
      for (int k = 0; k < 8; k++)
        check({req, " word"}, 64'(wq[k]), 64'({3'(k), exp_word(k, des, rf)}));
    end else if (exp_writes == 1 && wq.size() == 1) begin
      check({req, " header"}, 64'(wq[0]), 64'({3'd7, exp_word(7, des, rf)}));
    end
    if (exp_res == 2'd1) check({req, " no reads"}, 64'(nreads), 64'd0);
    @(negedge clk);
    check({req, " done one cycle"}, 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    check({req, " result held"}, 64'(result), 64'(exp_res));
    check({req, " idle"}, 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_destroy = 1'b0; cmd_reset_fn = 1'b0;
    a_evt = 64'hA123_4567_89AB_C000; a_cmp = 64'h5000_0000_0000_1000;
    a_rcv = 64'h0000_0000_0001_0000; a_snd = 64'hFFFF_FFFF_FFFF_F000;
    vec_idx = 32'h0000_1234; poll_gap = 16'd0; mb_rdata = 32'h0;
    pre_left = 0; post_left = 0; resp_word = 32'h0; wrote7 = 1'b0; nreads = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 result", 64'(result), 64'd0);
    check("R1 strobes", 64'({mb_rd, mb_wr}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({busy, done, mb_rd, mb_wr}), 64'd0);

    // R5 R6 R7 R3 R11: establish with gaps and busy polls both phases
    run("R5 establish", 1'b0, 1'b0, 3, 2, 1, 32'h0000_0081, 2'd0,
        2 + phase_len(2, 3) + 8 + phase_len(1, 3), 8, 1'b0);
    // R7 reset flag in header, good response, no gap
    run("R7 establish rf", 1'b0, 1'b1, 0, 0, 0, 32'h0100_0081, 2'd0,
        2 + phase_len(0, 0) + 8 + phase_len(0, 0), 8, 1'b0);
    // R8 destroy with reset flag: all-ones reply is success
    run("R8 destroy rf", 1'b1, 1'b1, 2, 1, 0, 32'hFFFF_FFFF, 2'd0,
        2 + phase_len(1, 2) + 1 + phase_len(0, 2), 1, 1'b0);
    // R6 destroy normal response
    run("R6 destroy", 1'b1, 1'b0, 0, 0, 3, 32'h0000_0082, 2'd0,
        2 + phase_len(0, 0) + 1 + phase_len(3, 0), 1, 1'b0);
    // R9 protocol errors
    run("R9 wrong type", 1'b1, 1'b0, 0, 0, 0, 32'h0000_0081, 2'd3,
        2 + 2 + 1 + 2, 1, 1'b0);
    run("R9 newer version", 1'b0, 1'b0, 0, 0, 0, 32'h0000_0089, 2'd3,
        2 + 2 + 8 + 2, 8, 1'b0);
    run("R9 request direction", 1'b0, 1'b0, 0, 0, 0, 32'h0000_0001, 2'd3,
        2 + 2 + 8 + 2, 8, 1'b0);
    run("R9 status set", 1'b1, 1'b0, 0, 0, 0, 32'h0000_0582, 2'd3,
        2 + 2 + 1 + 2, 1, 1'b0);
    // R10 start while busy ignored
    run("R10 ignore start", 1'b0, 1'b0, 1, 1, 0, 32'h0000_0081, 2'd0,
        2 + phase_len(1, 1) + 8 + phase_len(0, 1), 8, 1'b1);
    // R2 invalid arguments
    a_cmp = 64'h5000_0000_0000_1800;
    run("R2 unaligned", 1'b0, 1'b0, 0, 0, 0, 32'h0000_0081, 2'd1, 2, 0, 1'b0);
    a_cmp = 64'h5000_0000_0000_1000; vec_idx = 32'h0001_0000;
    run("R2 wide vector", 1'b0, 1'b0, 0, 0, 0, 32'h0000_0081, 2'd1, 2, 0, 1'b0);
    vec_idx = 32'h0000_FFFF;
    // R4 timeout in first phase, nothing written
    run("R4 owner timeout", 1'b0, 1'b0, 0, 1000000, 0, 32'h0000_0081, 2'd2,
        2 + 2 * N, 0, 1'b0);
    // R8 without flag all-ones is busy, so response phase times out (R4)
    run("R8 no flag timeout", 1'b1, 1'b0, 0, 0, 0, 32'hFFFF_FFFF, 2'd2,
        2 + 2 + 1 + 2 * N, 1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule